// File: doc/BRIEF.md
# Two-Identity I2C Target Front End

This block is the bus side of a small serial memory. It runs on a fast system clock and watches an I2C clock and data pair through synchronizers. It recognises start and stop conditions, shifts bytes in and out with the most significant bit first, and answers to two device identities that share one chip-enable setting. One identity addresses the main storage array and the other addresses a protection register. The data line is open drain, so the block asserts an enable that pulls SDA low. It never drives SDA high.

After a matching select byte with a write direction, the next byte sets the word pointer. Every later byte is handed to the storage core as a one-cycle write strobe, and the pointer advances after each one. After a matching select byte with a read direction, the block asks the core for one byte per transfer with a one-cycle request. It shifts that byte out on SDA and advances the pointer. It keeps sending bytes while the controller acknowledges them. A random read is a write that carries only the word pointer, then a repeated start, then a read select.

The controller has ten states:
- IDLE: waits after reset or a stop.
- DEV: receives the select byte.
- DEV_ACK: drives the acknowledge for the select byte.
- ADDR and ADDR_ACK: receive and acknowledge the pointer byte.
- WDATA and WDATA_ACK: receive and acknowledge write data.
- RDATA: sends a data byte.
- RACK: samples the controller's acknowledge.
- SKIP: ignores the bus until the next start.

Transitions:
- Any state goes to IDLE on a stop, and to DEV on a start.
- DEV goes to DEV_ACK on a match and to SKIP otherwise, at the clock fall after the eighth bit.
- DEV_ACK goes to ADDR for a write and to RDATA for a read.
- ADDR goes to ADDR_ACK, then to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RACK. RACK goes back to RDATA on an acknowledge and to SKIP on a missing acknowledge.

Top module: `i2c_dual_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) restarts select-byte reception from any state, including partway through a byte. The bits already received are dropped.
- R2: A rising SDA while SCL is high (stop) returns the block to idle with SDA released. After reset, sda_oe, wr_stb and rd_req are all low.
- R3: A select byte whose top four bits are 1010 and whose bits 3..1 equal chip_en[2:0] is acknowledged. The block drives sda_oe high during the ninth clock and sets space_o to 0 (storage array).
- R4: A select byte whose top four bits are 0110 with matching chip-enable bits is acknowledged and sets space_o to 1 (protection register).
- R5: A select byte with any other type code, or with chip-enable bits that differ from chip_en, gets no acknowledge. Until the next start, sda_oe stays low and no wr_stb or rd_req is issued.
- R6: Bit 0 of an accepted select byte is latched on rw_o: 1 means read and 0 means write.
- R7: In a write, the first byte after the select byte is acknowledged and loaded into word_addr.
- R8: Each further write byte is acknowledged. For each one, wr_stb is high for exactly one cycle with the byte on wr_data and the target on word_addr. word_addr then steps by one and wraps from the top value to zero.
- R9: In a read, rd_req pulses for one cycle per byte. The block then sends rd_data as seen in that cycle, MSB first, each bit valid while SCL is high, and word_addr steps by one.
- R10: A controller acknowledge (SDA low on the ninth read clock) starts the next read byte. A missing acknowledge releases SDA, and no further rd_req is issued until the next start.
- R11: A write that carries only a word pointer, followed by a repeated start and a read select, returns data starting at that pointer.
- R12: sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| chip_en | input | 3 | Strapped chip-enable value compared with select bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| space_o | output | 1 | Target of the current transfer: 0 array, 1 protection register |
| rw_o | output | 1 | Direction of the current transfer: 1 read, 0 write |
| word_addr | output | 8 | Word pointer into the selected space |
| wr_data | output | 8 | Byte to store, valid with wr_stb |
| wr_stb | output | 1 | One-cycle write request at word_addr |
| rd_req | output | 1 | One-cycle read request; rd_data is captured in that cycle |
| rd_data | input | 8 | Byte from the core at word_addr in the selected space |

## Verification
A corrupted bit counter or state shows up at the bus within one byte time. Either the acknowledge lands on the wrong clock, or a read bit is shifted, and the controller sees it at the next ninth clock. A wrong pointer or space latch can stay hidden through a write. It shows up as wrong data on the read-back that follows, so every write is paired with a random read of the same range. A fault in the mismatch or no-acknowledge paths shows up as sda_oe activity, or as strobe and request pulses, during bytes that should be ignored. These are counted across whole transfers rather than at a single edge.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } st_e;

    typedef enum logic {
        SP_ARRAY = 1'b0,
        SP_PROT  = 1'b1
    } space_e;

endpackage

// File: rtl/i2c_dual_sync.sv
module i2c_dual_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_dual_cond.sv
module i2c_dual_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_dual_ctrl.sv
module i2c_dual_ctrl
    import i2c_dual_pkg::*;
#(
    parameter int         CE_W      = 3,
    parameter int         ADDR_W    = 8,
    parameter logic [3:0] ARR_TYPE  = 4'b1010,
    parameter logic [3:0] PROT_TYPE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [CE_W-1:0]   chip_en,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              space_o,
    output logic              rw_o,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              rd_req,
    output st_e               state_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    st_e               state;
    st_e               nxt;
    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mack_q;
    logic              byte_end;
    logic              type_arr;
    logic              type_prot;
    logic              hit;

    assign byte_end  = scl_fall && (cnt_q == LAST_BIT);
    assign type_arr  = (shift_q[7:4] == ARR_TYPE);
    assign type_prot = (shift_q[7:4] == PROT_TYPE);
    assign hit       = (type_arr || type_prot) && (shift_q[CE_W:1] == chip_en);
    assign state_o   = state;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (stop_evt) begin
            nxt = ST_IDLE;
        end else if (start_evt) begin
            nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: nxt = state;
                ST_DEV:           if (byte_end) nxt = hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:       if (scl_fall) nxt = rw_o ? ST_RDATA : ST_ADDR;
                ST_ADDR:          if (byte_end) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:      if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:         if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK:     if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:         if (byte_end) nxt = ST_RACK;
                ST_RACK:          if (scl_fall) nxt = mack_q ? ST_RDATA : ST_SKIP;
                default:          nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            cnt_q     <= '0;
            mack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            space_o   <= SP_ARRAY;
            rw_o      <= 1'b0;
            word_addr <= '0;
            wr_data   <= '0;
            wr_stb    <= 1'b0;
            rd_req    <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_req <= 1'b0;
            if (wr_stb) begin
                word_addr <= word_addr + 1'b1;
            end
            if (rd_req) begin
                word_addr <= word_addr + 1'b1;
                shift_q   <= rd_data;
                sda_oe    <= ~rd_data[BYTE_W-1];
            end
            if (stop_evt || start_evt) begin
                sda_oe <= 1'b0;
                cnt_q  <= '0;
            end else begin
                unique case (state)
                    ST_DEV, ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (byte_end) begin
                            cnt_q <= '0;
                            if (state == ST_DEV) begin
                                if (hit) begin
                                    sda_oe  <= 1'b1;
                                    space_o <= type_prot ? SP_PROT : SP_ARRAY;
                                    rw_o    <= shift_q[0];
                                end
                            end else if (state == ST_ADDR) begin
                                sda_oe    <= 1'b1;
                                word_addr <= ADDR_W'(shift_q);
                            end else begin
                                sda_oe  <= 1'b1;
                                wr_data <= shift_q;
                                wr_stb  <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (rw_o) rd_req <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (byte_end) begin
                            sda_oe <= 1'b0;
                            cnt_q  <= '0;
                        end else if (scl_fall && cnt_q != '0) begin
                            shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~shift_q[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall && mack_q) begin
                            rd_req <= 1'b1;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        sda_oe <= 1'b0;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
    import i2c_dual_pkg::*;
#(
    parameter int         CE_W      = 3,
    parameter int         ADDR_W    = 8,
    parameter int         SYNC_STG  = 2,
    parameter logic [3:0] ARR_TYPE  = 4'b1010,
    parameter logic [3:0] PROT_TYPE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CE_W-1:0]   chip_en,
    output logic              sda_oe,
    output logic              space_o,
    output logic              rw_o,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              rd_req,
    input  logic [BYTE_W-1:0] rd_data
);

    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_evt;
    logic stop_evt;
    st_e  ctrl_state;

    i2c_dual_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STG),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_i, sda_i}),
        .q    ({scl_s, sda_s})
    );

    i2c_dual_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_dual_ctrl #(
        .CE_W     (CE_W),
        .ADDR_W   (ADDR_W),
        .ARR_TYPE (ARR_TYPE),
        .PROT_TYPE(PROT_TYPE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .sda_s    (sda_s),
        .chip_en  (chip_en),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .space_o  (space_o),
        .rw_o     (rw_o),
        .word_addr(word_addr),
        .wr_data  (wr_data),
        .wr_stb   (wr_stb),
        .rd_req   (rd_req),
        .state_o  (ctrl_state)
    );

endmodule

// File: rtl/i2c_dual_chk.sv
module i2c_dual_chk
    import i2c_dual_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_evt,
    input st_e               ctrl_state,
    input logic              sda_oe,
    input logic              wr_stb,
    input logic              rd_req,
    input logic [ADDR_W-1:0] word_addr
);

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_req)); // R8

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R8

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (word_addr == ADDR_W'($past(word_addr) + 1'b1))); // R8

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R9

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (word_addr == ADDR_W'($past(word_addr) + 1'b1))); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe); // R2

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_SKIP) |-> (!sda_oe && !wr_stb && !rd_req)); // R5

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R12

endmodule

bind i2c_dual_slave i2c_dual_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .stop_evt  (stop_evt),
    .ctrl_state(ctrl_state),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .rd_req    (rd_req),
    .word_addr (word_addr)
);

// File: tb/test_i2c_dual_slave.sv
module test_i2c_dual_slave;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam logic [2:0] CE         = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe, space_o, rw_o, wr_stb, rd_req;
    logic [7:0] word_addr, wr_data, rd_data;

    logic [7:0] mem     [0:1][0:255];
    logic [7:0] exp_mem [0:1][0:255];
    int n_wr = 0, n_rd = 0, n_oe = 0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;
    assign rd_data = mem[space_o][word_addr];

    i2c_dual_slave i_i2c_dual_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .chip_en(CE),
        .sda_oe(sda_oe), .space_o(space_o), .rw_o(rw_o), .word_addr(word_addr),
        .wr_data(wr_data), .wr_stb(wr_stb), .rd_req(rd_req), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            mem[space_o][word_addr] <= wr_data;
            n_wr <= n_wr + 1;
        end
        if (rd_req) n_rd <= n_rd + 1;
        if (sda_oe) n_oe <= n_oe + 1;
    end

    function automatic logic [7:0] dev_code(input bit prot, input logic [2:0] ce, input bit rd);
        return {(prot ? 4'b0110 : 4'b1010), ce, rd};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask
    task automatic bus_start();
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask
    task automatic bit_out(input bit b);
        m_sda = b; half(); m_scl = 1'b1; half(); half(); m_scl = 1'b0; half();
    endtask
    task automatic bit_in(output bit b);
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); b = sda_bus; half(); m_scl = 1'b0; half();
    endtask
    task automatic send_byte(input logic [7:0] d, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(s);
        acked = !s;
    endtask
    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bit_in(s);
            d[i] = s;
        end
        bit_out(!give_ack);
    endtask

    task automatic wr_txn(input bit prot, input logic [7:0] a, input int n);
        bit ak;
        int w0;
        logic [7:0] d;
        string tg;
        tg = prot ? "R4" : "R3";
        w0 = n_wr;
        bus_start();
        send_byte(dev_code(prot, CE, 1'b0), ak);
        chk({tg, " select ack"}, ak, 1);
        chk({tg, " space"}, space_o, prot);
        chk("R6 write direction", rw_o, 0);
        send_byte(a, ak);
        chk("R7 pointer ack", ak, 1);
        chk("R7 pointer load", word_addr, a);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            exp_mem[prot][8'(a + i)] = d;
            send_byte(d, ak);
            chk("R8 data ack", ak, 1);
        end
        bus_stop();
        chk("R8 strobe count", n_wr - w0, n);
        chk("R2 released after stop", sda_oe, 0);
    endtask

    task automatic rd_txn(input bit prot, input logic [7:0] a, input int n);
        bit ak;
        int r0;
        logic [7:0] d;
        bus_start();
        send_byte(dev_code(prot, CE, 1'b0), ak);
        send_byte(a, ak);
        r0 = n_rd;
        bus_start();
        send_byte(dev_code(prot, CE, 1'b1), ak);
        chk("R11 read select ack", ak, 1);
        chk("R6 read direction", rw_o, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(i == 0 ? "R11 first byte at pointer" : "R9 read data", d, exp_mem[prot][8'(a + i)]);
        end
        bus_stop();
        chk("R10 request count", n_rd - r0, n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ak, b;
        int w0, o0, r0;
        logic [7:0] d;
        void'($urandom(32'd2024));
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 256; k++) begin
                mem[s][k] = 8'h00;
                exp_mem[s][k] = 8'h00;
            end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 reset sda_oe", sda_oe, 0);
        chk("R2 reset wr_stb", wr_stb, 0);
        chk("R2 reset rd_req", rd_req, 0);

        // array write/read, with pointer wrap
        wr_txn(1'b0, 8'h10, 3);
        rd_txn(1'b0, 8'h10, 3);
        wr_txn(1'b0, 8'hFE, 4);
        rd_txn(1'b0, 8'hFE, 4);
        // protection register space
        wr_txn(1'b1, 8'h10, 2);
        rd_txn(1'b1, 8'h10, 2);
        rd_txn(1'b0, 8'h10, 2);

        // R5: wrong chip enable
        w0 = n_wr; o0 = n_oe;
        bus_start();
        send_byte(dev_code(1'b0, CE ^ 3'b001, 1'b0), ak);
        chk("R5 ce mismatch ack", ak, 0);
        send_byte(8'h20, ak);
        send_byte(8'h55, ak);
        chk("R5 ce mismatch data ack", ak, 0);
        bus_stop();
        chk("R5 ce mismatch no strobe", n_wr - w0, 0);
        chk("R5 ce mismatch sda idle", n_oe - o0, 0);

        // R5: unknown type code 1011
        o0 = n_oe;
        bus_start();
        send_byte({4'b1011, CE, 1'b0}, ak);
        chk("R5 type mismatch ack", ak, 0);
        send_byte(8'h20, ak);
        bus_stop();
        chk("R5 type mismatch sda idle", n_oe - o0, 0);

        // R10: no acknowledge ends the read
        rd_txn(1'b0, 8'h10, 1);
        bus_start();
        send_byte(dev_code(1'b0, CE, 1'b1), ak);
        recv_byte(1'b0, d);
        r0 = n_rd;
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        chk("R10 released after no ack", d, 8'hFF);
        chk("R10 no request after no ack", n_rd - r0, 0);
        bus_stop();

        // R1: start partway through a select byte
        w0 = n_wr;
        bus_start();
        for (int i = 7; i >= 4; i--) bit_out(dev_code(1'b0, CE, 1'b0)>>i);
        wr_txn(1'b0, 8'h40, 1);
        chk("R1 restart after partial byte", n_wr - w0, 1);
        rd_txn(1'b0, 8'h40, 1);

        // R2: stop partway through a write, then bytes without start
        w0 = n_wr;
        bus_start();
        send_byte(dev_code(1'b0, CE, 1'b0), ak);
        send_byte(8'h50, ak);
        bus_stop();
        m_scl = 1'b0; half();
        send_byte(8'hA5, ak);
        chk("R2 no ack after stop", ak, 0);
        chk("R2 no strobe after stop", n_wr - w0, 0);
        m_sda = 1'b1; half(); m_scl = 1'b1; half();

        // random write / read-back
        for (int it = 0; it < 14; it++) begin
            bit pr;
            logic [7:0] a;
            int n;
            pr = 1'($urandom);
            a = 8'($urandom);
            n = 1 + int'($urandom % 4);
            wr_txn(pr, a, n);
            rd_txn(pr, a, n);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule